// File: doc/BRIEF.md
# Error-Interrupt Enable Command Port

This block keeps a 64-bit map of per-channel error-interrupt enables. Software cannot write the map directly. It changes the map through two write-only command bytes. One command byte turns enable bits on and the other turns them off.

Each command byte carries three things:

- a skip flag in its top bit;
- an "every channel" flag in bit 6;
- a 6-bit channel number.

A single byte write can therefore change one channel, change every channel, or change nothing. Both command bytes sit in the same aligned 32-bit word. One word write with both byte enables high applies a set and a clear in the same cycle, and the clear wins where the two overlap.

The map drives the interrupt logic through a 64-bit output. Software reads the map back as two 32-bit words on the same register bus. The bus has no wait states. Read data is combinational from the address, and a write takes effect on the clock edge that accepts it.

Top module: `irq_enable_cmd_port`

## Requirements
- R1: After a synchronous active-low reset, the enable map is all zeros and both map words read as zero.
- R2: A write to word 0x18 with byte enable 1 high and bus_wdata[15:8] = 8'b00cccccc sets the enable bit of channel c (0..63) and leaves every other bit unchanged.
- R3: In the set byte (bus_wdata[15:8]), bit 7 low and bit 6 high (values 64..127) set every implemented enable bit.
- R4: A write to word 0x18 with byte enable 0 high and bus_wdata[7:0] = 8'b00cccccc clears the enable bit of channel c and leaves the other bits unchanged.
- R5: In the clear byte (bus_wdata[7:0]), bit 7 low and bit 6 high zero the whole map.
- R6: A command byte with bit 7 set changes nothing, whatever its lower seven bits hold.
- R7: A command byte whose byte enable is low has no effect. Writes to any word other than 0x18 leave the map unchanged.
- R8: When a set and a clear arrive in the same write, the new map is (old | set) & ~clear, so clear wins on any shared channel.
- R9: A read of word 0x18 returns zero at all times.
- R10: A read of word 0x20 returns channels 63..32 and a read of word 0x24 returns channels 31..0, with the lowest channel of each half in bit 0.
- R11: The map changes on the first rising clock edge at which the write is presented, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, accepted on the same edge |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] are ignored |
| bus_be | input | 4 | Byte enables; bus_be[i] covers bus_wdata[8i+7:8i] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| err_irq_en | output | 64 | Enable map, bit n = channel n |

## Verification
The bench builds the block with its defaults: 64 implemented channels and an 8-bit address. With these values every single-channel code is a real channel, including the boundary channels 0, 31, 32 and 63. The all-channels code then covers the full map, so the two map halves and the bit that straddles them can all be observed. Combined set-and-clear words, skip flags and masked byte lanes are all driven against a bench model of the map.

// File: rtl/irqen_pkg.sv
// Package: shared constants and the command byte layout for the enable
// command port. Assumes big-endian byte placement inside a 32-bit word.
package irqen_pkg;
    localparam int MAP_W        = 64;
    localparam int HALF_W       = 32;
    localparam int LANES        = 4;
    localparam int CMD_WORD_OFS = 'h18;
    localparam int MAP_HI_OFS   = 'h20;
    localparam int MAP_LO_OFS   = 'h24;
    localparam int SET_LANE     = 1;   // byte 0x1A -> bits 15:8
    localparam int CLR_LANE     = 0;   // byte 0x1B -> bits 7:0
    localparam int N_CMD        = 2;

    // Command byte: skip flag, every-channel flag, channel number.
    typedef struct packed {
        logic       skip;
        logic       all;
        logic [5:0] chan;
    } cmd_byte_t;
endpackage

// File: rtl/irqen_cmd_decode.sv
// Module: irqen_cmd_decode
// Turns one command byte into a 64-bit channel mask. Assumes lane_wr is
// already qualified by the write strobe, the word address and the byte enable.
module irqen_cmd_decode
    import irqen_pkg::*;
#(
    parameter int NUM_CH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lane_wr,
    input  cmd_byte_t        cmd,
    output logic [MAP_W-1:0] mask
);
    localparam logic [MAP_W-1:0] IMPL_MASK = {MAP_W{1'b1}} >> (MAP_W - NUM_CH);

    // Purpose: build the mask for a single channel, for every channel, or for none.
    always_comb begin
        mask = '0;
        if (lane_wr && !cmd.skip) begin
            if (cmd.all) begin
                mask = IMPL_MASK;
            end else if (int'(cmd.chan) < NUM_CH) begin
                mask[cmd.chan] = 1'b1;
            end
        end
    end

    // R6: a skipped byte yields no mask bits
    p_skip_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_wr && cmd.skip) |-> (mask == '0));
    // R7: a lane that is not written yields no mask bits
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_wr |-> (mask == '0));
    // R2: a single-channel code touches at most one bit
    p_single_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_wr && !cmd.skip && !cmd.all) |-> ($countones(mask) <= 1));
endmodule

// File: rtl/irqen_map_reg.sv
// Module: irqen_map_reg
// Holds the enable map and applies set and clear masks in one cycle,
// with the clear mask taking priority. Assumes both masks are already decoded.
module irqen_map_reg
    import irqen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MAP_W-1:0] set_mask,
    input  logic [MAP_W-1:0] clr_mask,
    output logic [MAP_W-1:0] map_q
);
    // Purpose: update the map register, clearing it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= '0;
        end else begin
            map_q <= (map_q | set_mask) & ~clr_mask;
        end
    end

    // R7: with no command the map holds its value
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_mask == '0) && (clr_mask == '0)) |=> $stable(map_q));
    // R8: every cleared channel is off afterwards
    p_clr_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((map_q & $past(clr_mask)) == '0));
    // R2: every set channel that is not also cleared is on afterwards
    p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((map_q & ($past(set_mask) & ~$past(clr_mask)))
                  == ($past(set_mask) & ~$past(clr_mask))));
endmodule

// File: rtl/irqen_read_mux.sv
// Module: irqen_read_mux
// Returns bus read data from the word address: the two map halves, or zero
// for the write-only command word and any unmapped word.
module irqen_read_mux
    import irqen_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-3:0] word_addr,
    input  logic [MAP_W-1:0]  map_q,
    output logic [31:0]       rdata
);
    localparam logic [ADDR_W-3:0] HI_WA  = (ADDR_W-2)'(MAP_HI_OFS >> 2);
    localparam logic [ADDR_W-3:0] LO_WA  = (ADDR_W-2)'(MAP_LO_OFS >> 2);
    localparam logic [ADDR_W-3:0] CMD_WA = (ADDR_W-2)'(CMD_WORD_OFS >> 2);

    // Purpose: select the read word for the current address.
    always_comb begin
        unique case (word_addr)
            HI_WA:   rdata = map_q[MAP_W-1:HALF_W];
            LO_WA:   rdata = map_q[HALF_W-1:0];
            default: rdata = '0;
        endcase
    end

    // R9: the command word always reads as zero
    p_cmd_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (word_addr == CMD_WA) |-> (rdata == '0));
endmodule

// File: rtl/irq_enable_cmd_port.sv
// Module: irq_enable_cmd_port
// Top of the enable command port. It qualifies writes to the command word,
// decodes the set and clear byte lanes, updates the map and serves reads.
// Assumes a zero-wait-state bus on which a write is taken at the edge where
// bus_we is high.
module irq_enable_cmd_port
    import irqen_pkg::*;
#(
    parameter int NUM_CH = 64,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LANES-1:0]  bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [MAP_W-1:0]  err_irq_en
);
    localparam logic [ADDR_W-3:0] CMD_WA = (ADDR_W-2)'(CMD_WORD_OFS >> 2);

    logic [ADDR_W-3:0] word_addr;
    logic              cmd_hit;
    logic [MAP_W-1:0]  lane_mask [N_CMD];

    assign word_addr = bus_addr[ADDR_W-1:2];
    assign cmd_hit   = bus_we && (word_addr == CMD_WA);

    // Generate block 0 decodes the set lane and block 1 the clear lane.
    for (genvar g = 0; g < N_CMD; g++) begin : g_lane
        localparam int LANE = (g == 0) ? SET_LANE : CLR_LANE;
        irqen_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
            .clk     (clk),
            .rst_n   (rst_n),
            .lane_wr (cmd_hit && bus_be[LANE]),
            .cmd     (cmd_byte_t'(bus_wdata[8*LANE +: 8])),
            .mask    (lane_mask[g])
        );
    end

    irqen_map_reg u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (lane_mask[0]),
        .clr_mask (lane_mask[1]),
        .map_q    (err_irq_en)
    );

    irqen_read_mux #(.ADDR_W(ADDR_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_addr (word_addr),
        .map_q     (err_irq_en),
        .rdata     (bus_rdata)
    );

    // R7: a write to another word leaves the map unchanged
    p_other_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (word_addr != CMD_WA)) |=> $stable(err_irq_en));
endmodule

// File: tb/sim_irq_enable_cmd_port.sv
// Scoreboard bench: the driver pushes expected maps, and the monitor pops
// them after each edge and compares them with the design's output.
module sim_irq_enable_cmd_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] err_irq_en;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] model = '0;
    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    irq_enable_cmd_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .err_irq_en(err_irq_en)
    );

    function automatic logic [63:0] cmd_mask(input logic [7:0] b, input logic en);
        if (!en || b[7]) return '0;
        if (b[6]) return {64{1'b1}};
        return 64'd1 << b[5:0];
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: present a write, check the map is unchanged before the edge (R11)
    task automatic do_write(input string req, input logic [7:0] addr,
                            input logic [3:0] be, input logic [31:0] data);
        logic hit;
        @(negedge clk);
        bus_we = 1'b1; bus_addr = addr; bus_be = be; bus_wdata = data;
        hit = (addr[7:2] == 6'h06);
        #1 check("R11", err_irq_en, model);
        model = (model | cmd_mask(data[15:8], hit && be[1]))
                & ~cmd_mask(data[7:0], hit && be[0]);
        exp_q.push_back(model);
        tag_q.push_back(req);
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; bus_be = '0;
    endtask

    task automatic do_read(input string req, input logic [7:0] addr, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = addr;
        #1 check(req, {32'd0, bus_rdata}, {32'd0, exp});
    endtask

    // Monitor: after each edge, compare the map with the next expected value.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                check(tag_q.pop_front(), err_irq_en, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 check("R1", err_irq_en, '0);
        @(negedge clk) rst_n = 1'b1;
        do_read("R1", 8'h20, 32'h0);
        do_read("R1", 8'h24, 32'h0);
        do_write("R2", 8'h18, 4'b0010, 32'h0000_0500);   // set ch5
        do_write("R2", 8'h18, 4'b0010, 32'h0000_3F00);   // set ch63
        do_write("R2", 8'h1A, 4'b0010, 32'h0000_2000);   // set ch32
        do_write("R2", 8'h18, 4'b0010, 32'h0000_0000);   // set ch0
        do_read("R10", 8'h20, 32'h8000_0001);
        do_read("R10", 8'h24, 32'h0000_0021);
        do_write("R4", 8'h18, 4'b0001, 32'h0000_0005);   // clear ch5
        do_write("R6", 8'h18, 4'b0011, 32'h0000_8583);   // both skipped
        do_write("R7", 8'h18, 4'b1100, 32'h0707_0707);   // lanes masked
        do_write("R7", 8'h20, 4'b1111, 32'h0000_4040);   // other word
        do_write("R3", 8'h18, 4'b0010, 32'h0000_4000);
        do_read("R10", 8'h24, 32'hFFFF_FFFF);
        do_write("R4", 8'h18, 4'b0001, 32'h0000_001F);   // clear ch31
        do_read("R10", 8'h24, 32'h7FFF_FFFF);
        do_write("R8", 8'h18, 4'b0011, 32'h0000_0A0A);   // set+clear ch10
        do_write("R5", 8'h18, 4'b0001, 32'h0000_007F);
        do_write("R3", 8'h18, 4'b0010, 32'h0000_7F00);
        do_write("R8", 8'h18, 4'b0011, 32'h0000_0340);   // set 3, clear all
        do_write("R2", 8'h18, 4'b1111, 32'hFFFF_2A80);   // set 42, clear skipped
        do_read("R9", 8'h18, 32'h0);
        do_read("R9", 8'h1B, 32'h0);
        do_write("R5", 8'h18, 4'b0001, 32'h0000_0055);
        do_read("R10", 8'h20, 32'h0);
        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule